// File: doc/BRIEF.md
# Abort Exception Routing Unit

This block decides where a synchronous abort is taken. A fault report arrives with a single-cycle `in_valid` pulse. It says whether the fault came from an instruction fetch or a data access, and whether it was an external abort, a stage-two translation fault or a register access made for the nested-virtualisation feature. Alongside it come the current privilege level (0 to 3), the implemented and enabled levels, the optional-feature flags and the trap-control bits.

One clock later the unit presents several results under `out_valid`:
- the privilege level that takes the exception;
- the offset into that level's vector table;
- a six-bit exception class code;
- the faulting virtual address;
- the optional intermediate physical address;
- the preferred return address.

Routing follows a layered priority. External-abort routing to level 3 wins first, then the hypervisor controls for level 2, and level 1 is the fallback. A double-fault option moves external aborts taken at level 3 to a separate vector slot. All results are registered and hold between requests.

Top module: `abort_route`

## Requirements
- R1: `out_valid` is high exactly in the cycle after each cycle with `in_valid` high (back-to-back requests give back-to-back results). While `out_valid` is low, every result output keeps its last value.
- R2: A synchronous active-high `rst` clears `out_valid` and every result output to zero.
- R3: Level-3 routing is active when `has_l3`, `cfg_ext_to_l3` and `ext_abort` are all set.
- R4: Level-2 routing is active only when `cur_lvl` is 0 or 1 and `l2_enabled` is set, together with at least one of the following:
  - `cfg_trap_all` is set;
  - `has_ras`, `cfg_trap_ext` and `ext_abort` are all set;
  - `stage2` is set;
  - the nested-virtualisation condition of R5 holds.
- R5: The nested-virtualisation condition is `has_nv`, with `nv_reg_access` set and `fetch_side` low. When it holds, the class is 0x27. For instruction fetches, or without `has_nv`, `nv_reg_access` has no effect.
- R6: `tgt_lvl` is 3 if `cur_lvl` is 3 or level-3 routing is active. Otherwise it is 2 if `cur_lvl` is 2 or level-2 routing is active. Otherwise it is 1.
- R7: `vec_off` is 0x180 when `has_dfault`, `ext_abort` and `cfg_ext_sel` are set and `tgt_lvl` is 3. In every other case it is 0x000.
- R8: Outside R5, `exc_class` depends on the fault side and on whether `tgt_lvl` is above `cur_lvl`:

  | Fault side | Target above current | Target equal to current |
  |---|---|---|
  | Instruction fetch | 0x20 | 0x21 |
  | Data | 0x24 | 0x25 |

- R9: `ret_addr` equals the `instr_pc` presented with the request, and `fault_va_q` equals `fault_va`.
- R10: When `ipa_ok` is set, `ipa_valid`, `ipa_ns_q` and `ipa_q` capture the flag, `ipa_ns` and `ipa_addr`. Otherwise all three are zero.
- R11: An instruction-fetch external abort marked asynchronous while `has_dfault` is set is flagged as an assertion error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fault report present this cycle |
| fetch_side | input | 1 | 1 = instruction fetch, 0 = data access |
| ext_abort | input | 1 | Fault is an external abort |
| async_abort | input | 1 | External abort is asynchronous |
| stage2 | input | 1 | Fault raised by stage-two translation |
| nv_reg_access | input | 1 | Access made for nested-virtualisation register redirection |
| cur_lvl | input | 2 | Current privilege level |
| has_l3 | input | 1 | Level 3 implemented |
| l2_enabled | input | 1 | Level 2 enabled for current state |
| has_ras | input | 1 | Reliability feature present |
| has_nv | input | 1 | Nested-virtualisation feature present |
| has_dfault | input | 1 | Double-fault feature present |
| cfg_ext_to_l3 | input | 1 | Route external aborts to level 3 |
| cfg_ext_sel | input | 1 | Select separate level-3 vector for external aborts |
| cfg_trap_all | input | 1 | Hypervisor general trap to level 2 |
| cfg_trap_ext | input | 1 | Hypervisor trap of external aborts |
| fault_va | input | VA_W | Faulting virtual address |
| ipa_ok | input | 1 | Intermediate physical address is valid |
| ipa_ns | input | 1 | Security bit of the intermediate address |
| ipa_addr | input | IPA_W | Intermediate physical address |
| instr_pc | input | VA_W | Address of the faulting instruction |
| out_valid | output | 1 | Result valid (one cycle per request) |
| tgt_lvl | output | 2 | Target privilege level |
| vec_off | output | 12 | Vector offset |
| exc_class | output | 6 | Exception class code |
| fault_va_q | output | VA_W | Captured virtual address |
| ipa_valid | output | 1 | Captured intermediate address valid |
| ipa_ns_q | output | 1 | Captured security bit |
| ipa_q | output | IPA_W | Captured intermediate address |
| ret_addr | output | VA_W | Preferred return address |

## Verification
Every result of a request is due at the first clock edge after the cycle in which `in_valid` is high, so all of them appear together one cycle later under `out_valid`. The driver raises `in_valid` just after a falling edge and pushes the expected record at that moment. The monitor samples on falling edges, which lies half a period after the edge that updates the outputs, and pops one record for each cycle with `out_valid` high. On idle cycles it compares the outputs against the last record to confirm they hold, and a reset issued after traffic checks that everything clears by the next sample.

// File: rtl/abort_route.sv
module abort_route #(
  parameter int VA_W  = 64,
  parameter int IPA_W = 52
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             fetch_side,
  input  logic             ext_abort,
  input  logic             async_abort,
  input  logic             stage2,
  input  logic             nv_reg_access,
  input  logic [1:0]       cur_lvl,
  input  logic             has_l3,
  input  logic             l2_enabled,
  input  logic             has_ras,
  input  logic             has_nv,
  input  logic             has_dfault,
  input  logic             cfg_ext_to_l3,
  input  logic             cfg_ext_sel,
  input  logic             cfg_trap_all,
  input  logic             cfg_trap_ext,
  input  logic [VA_W-1:0]  fault_va,
  input  logic             ipa_ok,
  input  logic             ipa_ns,
  input  logic [IPA_W-1:0] ipa_addr,
  input  logic [VA_W-1:0]  instr_pc,
  output logic             out_valid,
  output logic [1:0]       tgt_lvl,
  output logic [11:0]      vec_off,
  output logic [5:0]       exc_class,
  output logic [VA_W-1:0]  fault_va_q,
  output logic             ipa_valid,
  output logic             ipa_ns_q,
  output logic [IPA_W-1:0] ipa_q,
  output logic [VA_W-1:0]  ret_addr
);

  localparam logic [11:0] VEC_SPLIT = 12'h180;
  localparam logic [5:0]  EC_I_UP   = 6'h20;
  localparam logic [5:0]  EC_I_SAME = 6'h21;
  localparam logic [5:0]  EC_D_UP   = 6'h24;
  localparam logic [5:0]  EC_D_SAME = 6'h25;
  localparam logic [5:0]  EC_NV     = 6'h27;

  logic       low_lvl, nv_hit, to_l3, to_l2, rise;
  logic [1:0] lvl_n;
  logic [11:0] vec_n;
  logic [5:0] ec_n;

  assign low_lvl = (cur_lvl == 2'd0) || (cur_lvl == 2'd1);
  assign nv_hit  = has_nv && nv_reg_access && !fetch_side;
  assign to_l3   = has_l3 && cfg_ext_to_l3 && ext_abort;
  assign to_l2   = low_lvl && l2_enabled &&
                   (cfg_trap_all || (has_ras && cfg_trap_ext && ext_abort) ||
                    nv_hit || stage2);

  assign lvl_n = (cur_lvl == 2'd3 || to_l3) ? 2'd3 :
                 (cur_lvl == 2'd2 || to_l2) ? 2'd2 : 2'd1;

  assign vec_n = (has_dfault && ext_abort && cfg_ext_sel && lvl_n == 2'd3)
                 ? VEC_SPLIT : 12'h000;

  assign rise = lvl_n > cur_lvl;
  assign ec_n = nv_hit     ? EC_NV :
                fetch_side ? (rise ? EC_I_UP : EC_I_SAME) :
                             (rise ? EC_D_UP : EC_D_SAME);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      tgt_lvl    <= '0;
      vec_off    <= '0;
      exc_class  <= '0;
      fault_va_q <= '0;
      ipa_valid  <= 1'b0;
      ipa_ns_q   <= 1'b0;
      ipa_q      <= '0;
      ret_addr   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        tgt_lvl    <= lvl_n;
        vec_off    <= vec_n;
        exc_class  <= ec_n;
        fault_va_q <= fault_va;
        ipa_valid  <= ipa_ok;
        ipa_ns_q   <= ipa_ok && ipa_ns;
        ipa_q      <= ipa_ok ? ipa_addr : '0;
        ret_addr   <= instr_pc;
      end
    end
  end

endmodule

module abort_route_chk #(
  parameter int VA_W  = 64,
  parameter int IPA_W = 52
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             fetch_side,
  input logic             ext_abort,
  input logic             async_abort,
  input logic             has_dfault,
  input logic [1:0]       cur_lvl,
  input logic [VA_W-1:0]  instr_pc,
  input logic             out_valid,
  input logic [1:0]       tgt_lvl,
  input logic [11:0]      vec_off,
  input logic             ipa_valid,
  input logic [IPA_W-1:0] ipa_q,
  input logic [VA_W-1:0]  ret_addr
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(tgt_lvl) && $stable(ret_addr) && $stable(vec_off))); // R1
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && tgt_lvl == 2'd0)); // R2
  AST_L3_STAYS: assert property (@(posedge clk) disable iff (rst) (in_valid && cur_lvl == 2'd3) |=> tgt_lvl == 2'd3); // R6
  AST_NEVER_L0: assert property (@(posedge clk) disable iff (rst) out_valid |-> tgt_lvl != 2'd0); // R6
  AST_VEC_ONLY_L3: assert property (@(posedge clk) disable iff (rst) (out_valid && vec_off != 12'h000) |-> (tgt_lvl == 2'd3 && vec_off == 12'h180)); // R7
  AST_RET_PC: assert property (@(posedge clk) disable iff (rst) in_valid |=> ret_addr == $past(instr_pc)); // R9
  AST_IPA_ZERO: assert property (@(posedge clk) disable iff (rst) (out_valid && !ipa_valid) |-> ipa_q == '0); // R10
  AST_IFETCH_SYNC: assert property (@(posedge clk) disable iff (rst) (in_valid && fetch_side && ext_abort && has_dfault) |-> !async_abort); // R11

endmodule

bind abort_route abort_route_chk #(.VA_W(VA_W), .IPA_W(IPA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .fetch_side(fetch_side),
  .ext_abort(ext_abort), .async_abort(async_abort), .has_dfault(has_dfault),
  .cur_lvl(cur_lvl), .instr_pc(instr_pc), .out_valid(out_valid),
  .tgt_lvl(tgt_lvl), .vec_off(vec_off), .ipa_valid(ipa_valid),
  .ipa_q(ipa_q), .ret_addr(ret_addr)
);

// File: tb/abort_route_test.sv
module abort_route_test;
  localparam int VA_W = 64;
  localparam int IPA_W = 52;

  typedef struct {
    string            tag;
    logic [1:0]       lvl;
    logic [11:0]      vec;
    logic [5:0]       ec;
    logic [VA_W-1:0]  va;
    logic [VA_W-1:0]  pc;
    logic             iv;
    logic             ns;
    logic [IPA_W-1:0] ipa;
  } exp_t;

  logic clk = 0, rst = 1, in_valid = 0;
  logic fetch_side, ext_abort, async_abort, stage2, nv_reg_access;
  logic [1:0] cur_lvl;
  logic has_l3, l2_enabled, has_ras, has_nv, has_dfault;
  logic cfg_ext_to_l3, cfg_ext_sel, cfg_trap_all, cfg_trap_ext;
  logic [VA_W-1:0] fault_va, instr_pc;
  logic ipa_ok, ipa_ns;
  logic [IPA_W-1:0] ipa_addr;
  logic out_valid, ipa_valid, ipa_ns_q;
  logic [1:0] tgt_lvl;
  logic [11:0] vec_off;
  logic [5:0] exc_class;
  logic [VA_W-1:0] fault_va_q, ret_addr;
  logic [IPA_W-1:0] ipa_q;

  int checks = 0, errors = 0;
  exp_t q[$];
  exp_t last;
  bit have_last = 0;

  always #2 clk = ~clk;

  abort_route #(.VA_W(VA_W), .IPA_W(IPA_W)) uut (.*);

  task automatic chk(input string tag, input logic [VA_W-1:0] act, input logic [VA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_cfg();
    fetch_side = 0; ext_abort = 0; async_abort = 0; stage2 = 0; nv_reg_access = 0;
    cur_lvl = 0; has_l3 = 0; l2_enabled = 0; has_ras = 0; has_nv = 0; has_dfault = 0;
    cfg_ext_to_l3 = 0; cfg_ext_sel = 0; cfg_trap_all = 0; cfg_trap_ext = 0;
    ipa_ok = 0; ipa_ns = 0; ipa_addr = '0;
    fault_va = 64'h0000_1234_5678_9ab0; instr_pc = 64'h0000_0000_4000_1000;
  endtask

  // expected values from R3..R10
  task automatic fire(input string tag);
    exp_t e;
    logic r3, r2, nv;
    nv = has_nv && nv_reg_access && !fetch_side;
    r3 = has_l3 && cfg_ext_to_l3 && ext_abort;
    r2 = (cur_lvl <= 1) && l2_enabled &&
         (cfg_trap_all || (has_ras && cfg_trap_ext && ext_abort) || nv || stage2);
    e.tag = tag;
    e.lvl = (cur_lvl == 3 || r3) ? 2'd3 : (cur_lvl == 2 || r2) ? 2'd2 : 2'd1;
    e.vec = (has_dfault && ext_abort && cfg_ext_sel && e.lvl == 3) ? 12'h180 : 12'h0;
    if (nv) e.ec = 6'h27;
    else if (fetch_side) e.ec = (e.lvl > cur_lvl) ? 6'h20 : 6'h21;
    else e.ec = (e.lvl > cur_lvl) ? 6'h24 : 6'h25;
    e.va = fault_va; e.pc = instr_pc;
    e.iv = ipa_ok; e.ns = ipa_ok && ipa_ns; e.ipa = ipa_ok ? ipa_addr : '0;
    q.push_back(e);
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst) have_last = 0;
      else if (out_valid) begin
        if (q.size() == 0) chk("R1 unexpected out_valid", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk({e.tag, " level"}, tgt_lvl, e.lvl);
          chk({e.tag, " vector"}, vec_off, e.vec);
          chk({e.tag, " class"}, exc_class, e.ec);
          chk({e.tag, " R9 va"}, fault_va_q, e.va);
          chk({e.tag, " R9 ret"}, ret_addr, e.pc);
          chk({e.tag, " R10 ipa valid"}, ipa_valid, e.iv);
          chk({e.tag, " R10 ns"}, ipa_ns_q, e.ns);
          chk({e.tag, " R10 ipa"}, ipa_q, e.ipa);
          last = e; have_last = 1;
        end
      end else if (have_last) begin
        chk("R1 hold level", tgt_lvl, last.lvl);
        chk("R1 hold class", exc_class, last.ec);
        chk("R1 hold ret", ret_addr, last.pc);
      end
    end
  end

  initial begin : watchdog
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    clear_cfg();
    idle(3);
    rst = 0;
    idle(1);
    chk("R2 reset valid", out_valid, 0);
    chk("R2 reset level", tgt_lvl, 0);
    chk("R2 reset ret", ret_addr, 0);

    fire("R8 data lvl0 to L1");
    fetch_side = 1; cur_lvl = 1; fire("R8 fetch same level");
    clear_cfg(); has_l3 = 1; cfg_ext_to_l3 = 1; ext_abort = 1; fire("R3 ext to L3");
    has_dfault = 1; cfg_ext_sel = 1; fire("R7 split vector at L3");
    cfg_ext_to_l3 = 0; cur_lvl = 1; fire("R7 no split below L3");
    cur_lvl = 3; fire("R7 split from current L3");
    has_l3 = 0; cfg_ext_to_l3 = 1; cur_lvl = 0; fire("R3 no L3 implemented");
    idle(4);
    clear_cfg(); l2_enabled = 1; cfg_trap_all = 1; fire("R4 trap-all to L2");
    l2_enabled = 0; fire("R4 L2 disabled");
    clear_cfg(); l2_enabled = 1; has_ras = 1; cfg_trap_ext = 1; ext_abort = 1; cur_lvl = 1;
    fire("R4 ras ext trap");
    has_ras = 0; fire("R4 no ras feature");
    clear_cfg(); l2_enabled = 1; stage2 = 1; fetch_side = 1; cur_lvl = 1; fire("R4 stage2 fetch");
    cur_lvl = 2; fire("R6 current L2 stays");
    clear_cfg(); l2_enabled = 1; cfg_trap_all = 1; cur_lvl = 2; fire("R4 level2 current no raise");
    clear_cfg(); has_nv = 1; nv_reg_access = 1; l2_enabled = 1; cur_lvl = 1; fire("R5 nv data to L2");
    fetch_side = 1; fire("R5 nv ignored on fetch");
    fetch_side = 0; has_nv = 0; fire("R5 nv ignored without feature");
    clear_cfg(); has_l3 = 1; cfg_ext_to_l3 = 1; ext_abort = 1; l2_enabled = 1; cfg_trap_all = 1;
    fire("R6 L3 over L2");
    idle(3);
    clear_cfg(); ipa_ok = 1; ipa_ns = 1; ipa_addr = 52'h8_7654_3210_fed0; fire("R10 ipa captured");
    ipa_ok = 0; fire("R10 ipa dropped");
    for (int i = 0; i < 6; i++) begin
      clear_cfg();
      fault_va = {$urandom, $urandom};
      instr_pc = {$urandom, $urandom} & ~64'h3;
      cur_lvl = 2'(i % 4);
      fetch_side = i[0];
      fire("R9 address capture");
    end
    idle(3);
    rst = 1; idle(1); rst = 0;
    chk("R2 mid reset valid", out_valid, 0);
    chk("R2 mid reset class", exc_class, 0);
    chk("R2 mid reset va", fault_va_q, 0);
    chk("R1 queue drained", q.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule